// File: doc/BRIEF.md
# DDR Supply Power-State Controller

This block is the digital state logic of a dual-rail memory power controller. A main rail feeds the memory array, and a termination rail follows half of the main rail. The block watches six status flags: a standby request, good flags for the 5 V standby supply and the 12 V main supply, a maximum-duty flag from the main switcher, and in-regulation flags for the main and termination rails. From these flags it selects one of three operating states: full-on, standby or off.

In full-on the external switcher runs. The termination regulator starts only after the main rail reports that it is in regulation. In standby only the internal standby switcher runs, and the termination output floats. In off everything is disabled and the fault latch is held clear. Each exit from off sends a one-cycle soft-start pulse. The open-drain power-good pin is released only in full-on, and only after both rails have stayed in regulation for a programmable hold time. All flags are asynchronous to the clock, so each one passes through a two-flop synchroniser before it is decoded.

Top module: `ddr_pwr_ctrl`

## Requirements
- R1: Every input flag passes through two synchroniser flops. A flag change driven just after clock edge N can first move the state register on edge N+3, and cannot move it earlier.
- R2: When the synchronised standby-supply-good flag is low, the next state is off, whatever the present state.
- R3: With standby supply good and the standby request low, the next state is full-on if the 12 V good flag is high, and off if it is low.
- R4: In full-on with the standby request high, the block stays in full-on only while 12 V good is high and max-duty is low. Otherwise it moves to standby.
- R5: With standby supply good and the standby request high, standby stays in standby and off stays in off.
- R6: The state is reported on `pwr_state` with off = 2'b00, full-on = 2'b01 and standby = 2'b10. `main_sw_en` is high only in full-on, `stby_sw_en` only in standby, and `fault_clr` only in off.
- R7: `term_en` is high only in full-on while the synchronised main in-regulation flag is high.
- R8: `pgood_pd` is low (pin released) only in full-on, with both in-regulation flags high, once they have been qualified for `HOLD_CYC` consecutive cycles. In every other case it is high.
- R9: The hold count restarts from zero whenever either in-regulation flag drops or the state leaves full-on.
- R10: `softstart` is a one-cycle pulse in the first cycle after the state leaves off. It never follows a move from standby to full-on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_req | input | 1 | Standby request (async) |
| stby_ok | input | 1 | 5 V standby supply good (async) |
| main_ok | input | 1 | 12 V supply good (async) |
| duty_max | input | 1 | Main switcher at maximum duty (async) |
| main_inreg | input | 1 | Main rail in regulation (async) |
| term_inreg | input | 1 | Termination rail in regulation (async) |
| pwr_state | output | 2 | Current state: 00 off, 01 full-on, 10 standby |
| main_sw_en | output | 1 | Enable for the external main-rail switcher gate drives |
| stby_sw_en | output | 1 | Enable for the internal standby switcher |
| term_en | output | 1 | Enable for the termination regulator |
| softstart | output | 1 | One-cycle soft-start restart pulse |
| fault_clr | output | 1 | Clears the overcurrent fault latch |
| pgood_pd | output | 1 | Power-good pull-down control (1 = pin pulled low) |

## Verification
A flag driven just after edge N changes the state, the switcher enables and `fault_clr` at the sample point of cycle N+3. The `softstart` pulse is seen in that same cycle only. `term_en` follows the main in-regulation flag at cycle N+2. The power-good release is due `HOLD_CYC` cycles after qualification begins, so it comes at N+2+HOLD_CYC for a late in-regulation flag and at N+3+HOLD_CYC for an entry into full-on. The driver stores each expected output word against its exact due cycle. The monitor compares, at the falling edge of that cycle, and also checks the cycle just before each release or transition. Any expectation whose due cycle passes without a comparison counts as a failure.

// File: rtl/ddr_pwr_pkg.sv
package ddr_pwr_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'b00,
    ST_ON   = 2'b01,
    ST_STBY = 2'b10
  } pwr_state_t;

  // Flag positions in the synchronised vector
  localparam int F_REQ    = 0;
  localparam int F_SOK    = 1;
  localparam int F_MOK    = 2;
  localparam int F_DUTY   = 3;
  localparam int F_MREG   = 4;
  localparam int F_TREG   = 5;
  localparam int N_FLAGS  = 6;

  // Next-state decode from the supply-monitor truth table
  function automatic pwr_state_t next_state(
    input pwr_state_t cur,
    input logic req, input logic sok, input logic mok, input logic duty
  );
    pwr_state_t nxt;
    if (!sok)            nxt = ST_OFF;
    else if (!req)       nxt = mok ? ST_ON : ST_OFF;
    else begin
      case (cur)
        ST_ON:   nxt = (mok && !duty) ? ST_ON : ST_STBY;
        ST_STBY: nxt = ST_STBY;
        default: nxt = ST_OFF;
      endcase
    end
    return nxt;
  endfunction

  // Saturating hold counter step
  function automatic int unsigned hold_step(
    input int unsigned cnt, input logic qual, input int unsigned limit
  );
    if (!qual)             return 0;
    else if (cnt >= limit) return limit;
    else                   return cnt + 1;
  endfunction

endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic meta_q, stab_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q <= 1'b0;
          stab_q <= 1'b0;
        end else begin
          meta_q <= d_async[i];
          stab_q <= meta_q;
        end
      end
      assign q_sync[i] = stab_q;
    end
  endgenerate

endmodule

// File: rtl/pwr_state_dec.sv
module pwr_state_dec
  import ddr_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_s,
  input  logic       sok_s,
  input  logic       mok_s,
  input  logic       duty_s,
  output pwr_state_t state,
  output logic       leave_off
);

  pwr_state_t state_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      prev_q  <= ST_OFF;
    end else begin
      state_q <= next_state(state_q, req_s, sok_s, mok_s, duty_s);
      prev_q  <= state_q;
    end
  end

  assign state     = state_q;
  assign leave_off = (prev_q == ST_OFF) && (state_q != ST_OFF);

  // R2
  stby_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sok_s |=> state_q == ST_OFF);

  // R4
  duty_escape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ON && sok_s && req_s && duty_s) |=> state_q == ST_STBY);

  // R5
  stby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STBY && sok_s && req_s) |=> state_q == ST_STBY);

endmodule

// File: rtl/pgood_hold.sv
module pgood_hold
  import ddr_pwr_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 40000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic qual,
  output logic release_ok
);

  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= CW'(hold_step(int'(cnt_q), qual, HOLD_CYC));
  end

  assign release_ok = qual && (cnt_q == LIMIT);

  // R9
  hold_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !qual |=> cnt_q == '0);

  // R8
  hold_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);

endmodule

// File: rtl/ddr_pwr_ctrl.sv
module ddr_pwr_ctrl
  import ddr_pwr_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 40000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stby_req,
  input  logic       stby_ok,
  input  logic       main_ok,
  input  logic       duty_max,
  input  logic       main_inreg,
  input  logic       term_inreg,
  output logic [1:0] pwr_state,
  output logic       main_sw_en,
  output logic       stby_sw_en,
  output logic       term_en,
  output logic       softstart,
  output logic       fault_clr,
  output logic       pgood_pd
);

  logic [N_FLAGS-1:0] flags_a, flags_s;
  pwr_state_t         state;
  logic               leave_off;
  logic               both_inreg;
  logic               hold_qual;
  logic               hold_done;

  assign flags_a[F_REQ]  = stby_req;
  assign flags_a[F_SOK]  = stby_ok;
  assign flags_a[F_MOK]  = main_ok;
  assign flags_a[F_DUTY] = duty_max;
  assign flags_a[F_MREG] = main_inreg;
  assign flags_a[F_TREG] = term_inreg;

  flag_sync #(.WIDTH(N_FLAGS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (flags_a),
    .q_sync  (flags_s)
  );

  pwr_state_dec u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_s     (flags_s[F_REQ]),
    .sok_s     (flags_s[F_SOK]),
    .mok_s     (flags_s[F_MOK]),
    .duty_s    (flags_s[F_DUTY]),
    .state     (state),
    .leave_off (leave_off)
  );

  assign both_inreg = flags_s[F_MREG] && flags_s[F_TREG];
  assign hold_qual  = (state == ST_ON) && both_inreg;

  pgood_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .qual       (hold_qual),
    .release_ok (hold_done)
  );

  assign pwr_state  = state;
  assign main_sw_en = (state == ST_ON);
  assign stby_sw_en = (state == ST_STBY);
  assign fault_clr  = (state == ST_OFF);
  assign term_en    = (state == ST_ON) && flags_s[F_MREG];
  assign softstart  = leave_off;
  assign pgood_pd   = !hold_done;

  // R6
  sw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({main_sw_en, stby_sw_en, fault_clr}));

  // R7
  term_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_en |-> (pwr_state == 2'b01 && main_sw_en));

  // R8
  pgood_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pgood_pd |-> (main_sw_en && flags_s[F_MREG] && flags_s[F_TREG]));

  // R10
  softstart_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    softstart |=> !softstart);

endmodule

// File: tb/ddr_pwr_ctrl_tb.sv
module ddr_pwr_ctrl_tb;

  localparam int H = 8;
  localparam logic [1:0] OFF = 2'b00, ON = 2'b01, SB = 2'b10;

  logic clk = 0, rst_n = 0;
  logic stby_req = 0, stby_ok = 0, main_ok = 0, duty_max = 0;
  logic main_inreg = 0, term_inreg = 0;
  logic [1:0] pwr_state;
  logic main_sw_en, stby_sw_en, term_en, softstart, fault_clr, pgood_pd;

  always #2.5 clk = ~clk;

  ddr_pwr_ctrl #(.HOLD_CYC(H)) u_dut (.*);

  typedef struct { int due; logic [7:0] v; string tag; } item_t;
  item_t q[$];
  int cyc = 0, tests = 0, fails = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Expected word: {state, main, stby, term, ss, fclr, pd}
  function automatic logic [7:0] expect_word(logic [1:0] st, logic term,
                                              logic ss, logic rel);
    return {st, st == ON, st == SB, term, ss, st == OFF, !rel};
  endfunction

  task automatic push(int dly, logic [1:0] st, logic term, logic ss,
                      logic rel, string tag);
    item_t it;
    it.due = cyc + dly; it.v = expect_word(st, term, ss, rel); it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Monitor
  always @(negedge clk) begin
    logic [7:0] act;
    act = {pwr_state, main_sw_en, stby_sw_en, term_en, softstart, fault_clr, pgood_pd};
    while (q.size() > 0 && q[0].due <= cyc) begin
      tests++;
      if (q[0].due < cyc) begin
        fails++;
        $display("FAIL %s: check missed at cycle %0d (actual %b expected %b)",
                 q[0].tag, q[0].due, act, q[0].v);
      end else if (act !== q[0].v) begin
        fails++;
        $display("FAIL %s: cycle %0d actual %b expected %b",
                 q[0].tag, cyc, act, q[0].v);
      end
      void'(q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    push(1, OFF, 0, 0, 0, "R6");                      // reset state
    idle(3);
    // R3: enter full-on; R1 timing; R10 soft-start
    stby_ok = 1; main_ok = 1;
    push(2, OFF, 0, 0, 0, "R1");
    push(3, ON, 0, 1, 0, "R3");
    push(4, ON, 0, 0, 0, "R10");
    idle(6);
    // R7: termination follows main in-regulation
    main_inreg = 1;
    push(1, ON, 0, 0, 0, "R7");
    push(2, ON, 1, 0, 0, "R7");
    idle(4);
    // R8: hold before release
    term_inreg = 1;
    push(H + 1, ON, 1, 0, 0, "R8");
    push(H + 2, ON, 1, 0, 1, "R8");
    idle(H + 4);
    // R9: drop restarts hold
    term_inreg = 0;
    push(2, ON, 1, 0, 0, "R9");
    idle(3);
    term_inreg = 1;
    push(H + 1, ON, 1, 0, 0, "R9");
    push(H + 2, ON, 1, 0, 1, "R9");
    idle(H + 4);
    // R4: standby request alone keeps full-on
    stby_req = 1;
    push(3, ON, 1, 0, 1, "R4");
    push(5, ON, 1, 0, 1, "R4");
    idle(6);
    // R4: max-duty escape to standby
    duty_max = 1;
    push(2, ON, 1, 0, 1, "R4");
    push(3, SB, 0, 0, 0, "R4");
    idle(4);
    duty_max = 0;
    push(4, SB, 0, 0, 0, "R5");
    idle(5);
    // Standby -> full-on: no soft-start, hold restarts
    stby_req = 0;
    push(3, ON, 1, 0, 0, "R10");
    push(2 + H, ON, 1, 0, 0, "R9");
    push(3 + H, ON, 1, 0, 1, "R8");
    idle(H + 5);
    // R4: 12 V loss with request -> standby
    stby_req = 1; main_ok = 0;
    push(3, SB, 0, 0, 0, "R4");
    idle(4);
    // R2: standby supply loss -> off
    stby_ok = 0;
    push(3, OFF, 0, 0, 0, "R2");
    idle(4);
    // R5: off stays off with request high
    stby_ok = 1; main_ok = 1;
    push(3, OFF, 0, 0, 0, "R5");
    push(6, OFF, 0, 0, 0, "R5");
    idle(7);
    // R3: request low, 12 V low -> off
    stby_req = 0; main_ok = 0;
    push(4, OFF, 0, 0, 0, "R3");
    idle(5);
    main_ok = 1;
    push(3, ON, 1, 1, 0, "R10");
    push(4, ON, 1, 0, 0, "R10");
    idle(5);
    // R2 from full-on
    stby_ok = 0;
    push(2, ON, 1, 0, 0, "R2");
    push(3, OFF, 0, 0, 0, "R2");
    idle(5);
    stby_ok = 1;
    push(3, ON, 1, 1, 0, "R10");
    idle(5);
    // R3: 12 V loss without request -> off
    main_ok = 0;
    push(3, OFF, 0, 0, 0, "R3");
    idle(6);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule